// File: doc/BRIEF.md
# Interrupt Controller Setup Sequencer

This block is the configuration front end of a programmable interrupt controller. It accepts byte writes from a host bus that has one address line (`a0`), a chip select and a write strobe. It follows the multi-word setup sequence, which may be two, three or four words long. It stores each configuration field as it arrives and holds the eight-bit request mask. The request-handling logic reads the stored settings from its outputs and waits for `init_done` before it services requests.

The first setup word is written with `a0` low and data bit 4 set, and it may arrive in any state. It restarts the sequence. It also clears the mask, the auto end-of-interrupt setting, the cascade map and the slave ID. The next `a0`-high write supplies the vector base. A cascade word follows only in cascaded operation, and a mode word follows only when the first word asks for one. The `master_sel` input decides whether the cascade word is read as a bitmask of attached slaves or as this device's slave ID. Outside the setup sequence, every `a0`-high write loads the mask.

States: `ST_UNINIT` (after reset, nothing programmed), `ST_W2` (waiting for the vector word), `ST_W3` (waiting for the cascade word), `ST_W4` (waiting for the mode word), `ST_READY` (programmed). Transitions: any state to `ST_W2` on a first-word write. `ST_W2` goes to `ST_W3`, `ST_W4` or `ST_READY` on an `a0`-high write, chosen by the stored cascade and mode flags. `ST_W3` goes to `ST_W4` or `ST_READY` on an `a0`-high write. `ST_W4` goes to `ST_READY` on an `a0`-high write. `ST_UNINIT` and `ST_READY` hold their state on `a0`-high writes, which load the mask.

Top module: `pic_init_seq`

## Requirements
- R1: After reset, `init_done`, `mask`, `vec_base`, `cascade_map`, `slave_id`, `auto_eoi`, `level_mode` and `single_mode` are all 0.
- R2: A strobed write with `a0`=0 and `din[4]`=1 restarts the sequence from any state. `level_mode` takes `din[3]`, `single_mode` takes `din[1]` and the mode-word flag takes `din[0]`. `mask`, `auto_eoi`, `cascade_map`, `slave_id` and `init_done` go to 0.
- R3: A strobed write with `a0`=0 and `din[4]`=0 changes no output.
- R4: The first `a0`=1 write after a restart stores `din[7:3]` as `vec_base`.
- R5: A cascade word is expected only when `single_mode`=0. With `master_sel`=1 it loads `cascade_map` from `din`. With `master_sel`=0 it loads `slave_id` from `din[2:0]`.
- R6: A mode word is expected only when the mode-word flag was 1. Its `din[1]` sets `auto_eoi`. Without a mode word, `auto_eoi` stays 0.
- R7: `init_done` rises one cycle after the last expected word. That gives 2, 3 or 4 words in total, depending on the stored flags.
- R8: While `ST_READY` holds, an `a0`=1 write loads `mask` from `din`. An `a0`=1 write inside the sequence never touches `mask`.
- R9: Before any first word, `a0`=1 writes load `mask`, and the value is retained until the next write or restart.
- R10: A write takes effect only in a cycle where `cs` and `wr` are both 1. Otherwise all outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select, active high |
| wr | input | 1 | Write strobe, active high, one cycle per write |
| a0 | input | 1 | Address line selecting the word type |
| din | input | 8 | Write data |
| master_sel | input | 1 | 1: cascade word is a slave bitmask; 0: cascade word is own slave ID |
| level_mode | output | 1 | 1 = level-triggered, 0 = edge-triggered |
| single_mode | output | 1 | 1 = single device, 0 = cascaded |
| vec_base | output | 5 | Upper bits of the interrupt vector |
| cascade_map | output | 8 | Request lines that have a slave attached |
| slave_id | output | 3 | This device's slave ID |
| auto_eoi | output | 1 | Automatic end-of-interrupt enabled |
| mask | output | 8 | Request mask, 1 disables the line |
| init_done | output | 1 | Setup sequence complete |

## Verification
The assertions assume that `din`, `a0` and `master_sel` are stable and known in any cycle where `cs` and `wr` are both high. They also assume that a write lasts exactly one cycle, so a single write is never counted as two. The bench changes its inputs only on falling edges and raises the strobe for a single cycle per write. It mixes random first words, cascade and mode flags and decoy writes with `a0` low. It also issues cycles with only one of `cs` and `wr` high. A model built from the requirements predicts every output after each write.

// File: rtl/pic_init_pkg.sv
package pic_init_pkg;
    typedef enum logic [2:0] {
        ST_UNINIT,
        ST_W2,
        ST_W3,
        ST_W4,
        ST_READY
    } seq_state_e;

    // bit positions inside the setup words
    localparam int unsigned FIRST_TAG_BIT = 4;
    localparam int unsigned LEVEL_BIT     = 3;
    localparam int unsigned SINGLE_BIT    = 1;
    localparam int unsigned NEED4_BIT     = 0;
    localparam int unsigned AEOI_BIT      = 1;
endpackage

// File: rtl/pic_init_fsm.sv
module pic_init_fsm
    import pic_init_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic       wr_hi,
    input  logic       need_w3,
    input  logic       need_w4,
    output seq_state_e state_q,
    output logic       ld_w2,
    output logic       ld_w3,
    output logic       ld_w4,
    output logic       ld_mask,
    output logic       done
);
    seq_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_UNINIT, ST_READY: state_d = state_q;
            ST_W2: if (wr_hi) state_d = need_w3 ? ST_W3 : (need_w4 ? ST_W4 : ST_READY);
            ST_W3: if (wr_hi) state_d = need_w4 ? ST_W4 : ST_READY;
            ST_W4: if (wr_hi) state_d = ST_READY;
            default: state_d = ST_UNINIT;
        endcase
        if (restart) state_d = ST_W2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_UNINIT;
        else        state_q <= state_d;
    end

    always_comb begin
        ld_w2   = 1'b0;
        ld_w3   = 1'b0;
        ld_w4   = 1'b0;
        ld_mask = 1'b0;
        done    = 1'b0;
        unique case (state_q)
            ST_UNINIT: ld_mask = wr_hi;
            ST_W2:     ld_w2   = wr_hi;
            ST_W3:     ld_w3   = wr_hi;
            ST_W4:     ld_w4   = wr_hi;
            ST_READY: begin
                ld_mask = wr_hi;
                done    = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pic_init_cfg.sv
module pic_init_cfg
    import pic_init_pkg::*;
#(
    parameter int unsigned LINES = 8,
    localparam int unsigned ID_W = $clog2(LINES),
    localparam int unsigned VB_W = LINES - ID_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             ld_w2,
    input  logic             ld_w3,
    input  logic             ld_w4,
    input  logic             master_sel,
    input  logic [LINES-1:0] din,
    output logic             level_mode,
    output logic             single_mode,
    output logic             need_w4,
    output logic [VB_W-1:0]  vec_base,
    output logic [LINES-1:0] cascade_map,
    output logic [ID_W-1:0]  slave_id,
    output logic             auto_eoi
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_mode  <= 1'b0;
            single_mode <= 1'b0;
            need_w4     <= 1'b0;
            vec_base    <= '0;
            cascade_map <= '0;
            slave_id    <= '0;
            auto_eoi    <= 1'b0;
        end else if (restart) begin
            level_mode  <= din[LEVEL_BIT];
            single_mode <= din[SINGLE_BIT];
            need_w4     <= din[NEED4_BIT];
            cascade_map <= '0;
            slave_id    <= '0;
            auto_eoi    <= 1'b0;
        end else begin
            if (ld_w2) vec_base <= din[LINES-1:ID_W];
            if (ld_w3) begin
                if (master_sel) cascade_map <= din;
                else            slave_id    <= din[ID_W-1:0];
            end
            if (ld_w4) auto_eoi <= din[AEOI_BIT];
        end
    end
endmodule

// File: rtl/pic_init_mask.sv
module pic_init_mask #(
    parameter int unsigned LINES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             load,
    input  logic [LINES-1:0] din,
    output logic [LINES-1:0] mask
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    mask <= '0;
        else if (clear) mask <= '0;
        else if (load)  mask <= din;
    end
endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
    import pic_init_pkg::*;
#(
    parameter int unsigned LINES = 8,
    localparam int unsigned ID_W = $clog2(LINES),
    localparam int unsigned VB_W = LINES - ID_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs,
    input  logic             wr,
    input  logic             a0,
    input  logic [LINES-1:0] din,
    input  logic             master_sel,
    output logic             level_mode,
    output logic             single_mode,
    output logic [VB_W-1:0]  vec_base,
    output logic [LINES-1:0] cascade_map,
    output logic [ID_W-1:0]  slave_id,
    output logic             auto_eoi,
    output logic [LINES-1:0] mask,
    output logic             init_done
);
    logic       wr_stb, restart, wr_hi;
    logic       ld_w2, ld_w3, ld_w4, ld_mask, need_w4;
    seq_state_e state_q;

    assign wr_stb  = cs & wr;
    assign restart = wr_stb & ~a0 & din[FIRST_TAG_BIT];
    assign wr_hi   = wr_stb & a0;

    pic_init_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .wr_hi   (wr_hi),
        .need_w3 (~single_mode),
        .need_w4 (need_w4),
        .state_q (state_q),
        .ld_w2   (ld_w2),
        .ld_w3   (ld_w3),
        .ld_w4   (ld_w4),
        .ld_mask (ld_mask),
        .done    (init_done)
    );

    pic_init_cfg #(.LINES(LINES)) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart     (restart),
        .ld_w2       (ld_w2),
        .ld_w3       (ld_w3),
        .ld_w4       (ld_w4),
        .master_sel  (master_sel),
        .din         (din),
        .level_mode  (level_mode),
        .single_mode (single_mode),
        .need_w4     (need_w4),
        .vec_base    (vec_base),
        .cascade_map (cascade_map),
        .slave_id    (slave_id),
        .auto_eoi    (auto_eoi)
    );

    pic_init_mask #(.LINES(LINES)) u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (restart),
        .load  (ld_mask),
        .din   (din),
        .mask  (mask)
    );
endmodule

// File: rtl/pic_init_checker.sv
module pic_init_checker
    import pic_init_pkg::*;
#(
    parameter int unsigned LINES = 8,
    localparam int unsigned ID_W = $clog2(LINES),
    localparam int unsigned VB_W = LINES - ID_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs,
    input logic             wr,
    input logic             a0,
    input logic [LINES-1:0] din,
    input logic             single_mode,
    input logic [VB_W-1:0]  vec_base,
    input logic [LINES-1:0] cascade_map,
    input logic [ID_W-1:0]  slave_id,
    input logic             auto_eoi,
    input logic [LINES-1:0] mask,
    input logic             init_done,
    input seq_state_e       state_q
);
    assert_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr && !a0 && din[FIRST_TAG_BIT]) |=>
            (!init_done && mask == '0 && !auto_eoi && state_q == ST_W2));

    assert_ignore_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr && !a0 && !din[FIRST_TAG_BIT]) |=>
            ($stable(mask) && $stable(vec_base) && $stable(init_done) && $stable(auto_eoi)));

    assert_skip_w3_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_W3) |-> !single_mode);

    assert_aeoi_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(auto_eoi) |-> ($past(state_q) == ST_W4 && $past(cs && wr && a0)));

    assert_done_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> $past(cs && wr && a0));

    assert_mask_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr && a0 && (state_q == ST_READY || state_q == ST_UNINIT)) |=> (mask == $past(din)));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs && wr) |=> ($stable(mask) && $stable(vec_base) && $stable(cascade_map) &&
                         $stable(slave_id) && $stable(auto_eoi) && $stable(init_done) &&
                         $stable(state_q)));
endmodule

bind pic_init_seq pic_init_checker #(.LINES(LINES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs          (cs),
    .wr          (wr),
    .a0          (a0),
    .din         (din),
    .single_mode (single_mode),
    .vec_base    (vec_base),
    .cascade_map (cascade_map),
    .slave_id    (slave_id),
    .auto_eoi    (auto_eoi),
    .mask        (mask),
    .init_done   (init_done),
    .state_q     (state_q)
);

// File: tb/test_pic_init_seq.sv
module test_pic_init_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 1'b0, wr = 1'b0, a0 = 1'b0, master_sel = 1'b1;
    logic [7:0] din = 8'h00;
    logic       level_mode, single_mode, auto_eoi, init_done;
    logic [4:0] vec_base;
    logic [7:0] cascade_map, mask;
    logic [2:0] slave_id;

    int checks = 0;
    int errors = 0;

    // reference model, built from the requirements
    int         m_stage = 0; // 0 uninit, 1 w2, 2 w3, 3 w4, 4 ready
    logic       m_lvl = 0, m_sgl = 0, m_n4 = 0, m_aeoi = 0;
    logic [4:0] m_vb = 0;
    logic [7:0] m_cmap = 0, m_mask = 0;
    logic [2:0] m_sid = 0;

    always #10 clk = ~clk;

    pic_init_seq i_pic_init_seq (
        .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .a0(a0), .din(din),
        .master_sel(master_sel), .level_mode(level_mode), .single_mode(single_mode),
        .vec_base(vec_base), .cascade_map(cascade_map), .slave_id(slave_id),
        .auto_eoi(auto_eoi), .mask(mask), .init_done(init_done)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic chk_all(input string tag);
        chk(tag, "init_done", int'(init_done), int'(m_stage == 4));
        chk(tag, "mask", int'(mask), int'(m_mask));
        chk(tag, "vec_base", int'(vec_base), int'(m_vb));
        chk(tag, "cascade_map", int'(cascade_map), int'(m_cmap));
        chk(tag, "slave_id", int'(slave_id), int'(m_sid));
        chk(tag, "auto_eoi", int'(auto_eoi), int'(m_aeoi));
        chk(tag, "level_mode", int'(level_mode), int'(m_lvl));
        chk(tag, "single_mode", int'(single_mode), int'(m_sgl));
    endtask

    function automatic string model(input logic ad, input logic [7:0] d, input logic ms);
        if (!ad && d[4]) begin
            m_stage = 1; m_lvl = d[3]; m_sgl = d[1]; m_n4 = d[0];
            m_mask = 0; m_aeoi = 0; m_cmap = 0; m_sid = 0;
            return "R2";
        end
        if (!ad) return "R3";
        case (m_stage)
            0: begin m_mask = d; return "R9"; end
            4: begin m_mask = d; return "R8"; end
            1: begin
                m_vb = d[7:3];
                m_stage = !m_sgl ? 2 : (m_n4 ? 3 : 4);
                return "R4";
            end
            2: begin
                if (ms) m_cmap = d; else m_sid = d[2:0];
                m_stage = m_n4 ? 3 : 4;
                return "R5";
            end
            default: begin
                m_aeoi = d[1];
                m_stage = 4;
                return "R6";
            end
        endcase
    endfunction

    task automatic bus_wr(input logic ad, input logic [7:0] d);
        string tag;
        @(negedge clk);
        cs = 1'b1; wr = 1'b1; a0 = ad; din = d;
        @(negedge clk);
        cs = 1'b0; wr = 1'b0;
        tag = model(ad, d, master_sel);
        chk_all(tag);
    endtask

    task automatic half_wr(input logic c, input logic w, input logic ad, input logic [7:0] d);
        @(negedge clk);
        cs = c; wr = w; a0 = ad; din = d;
        @(negedge clk);
        cs = 1'b0; wr = 1'b0;
        chk_all("R10");
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk_all("R1");
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("R1");

        // R9: mask before any setup word
        bus_wr(1'b1, 8'hA5);
        repeat (3) @(negedge clk);
        chk("R9", "mask retained", int'(mask), 8'hA5);

        // R3: decoy write with a0 low
        bus_wr(1'b0, 8'h0B);

        // R7: four-word master sequence with auto EOI
        master_sel = 1'b1;
        bus_wr(1'b0, 8'h11);
        bus_wr(1'b1, 8'h20);
        chk("R7", "not done after w2", int'(init_done), 0);
        bus_wr(1'b1, 8'h04);
        chk("R7", "not done after w3", int'(init_done), 0);
        bus_wr(1'b1, 8'h03);
        chk("R7", "done after w4", int'(init_done), 1);
        bus_wr(1'b1, 8'hF0);

        // R5: slave ID path
        master_sel = 1'b0;
        bus_wr(1'b0, 8'h19);
        bus_wr(1'b1, 8'h70);
        bus_wr(1'b1, 8'hFE);
        bus_wr(1'b1, 8'h01);

        // R6: single, no mode word
        bus_wr(1'b0, 8'h1A);
        bus_wr(1'b1, 8'h08);
        chk("R6", "done after 2 words", int'(init_done), 1);

        // R2: restart mid-sequence
        bus_wr(1'b0, 8'h11);
        bus_wr(1'b1, 8'hC8);
        bus_wr(1'b0, 8'h13);
        bus_wr(1'b1, 8'h40);

        // R10: partial strobes
        half_wr(1'b1, 1'b0, 1'b1, 8'h5A);
        half_wr(1'b0, 1'b1, 1'b0, 8'h1F);

        for (int i = 0; i < 400; i++) begin
            int r;
            logic [7:0] d;
            r = int'($urandom_range(0, 99));
            d = 8'($urandom);
            if (r % 7 == 0) master_sel = ~master_sel;
            if (r < 15)      bus_wr(1'b0, d | 8'h10);
            else if (r < 22) bus_wr(1'b0, d & 8'hEF);
            else if (r < 27) half_wr(1'($urandom), 1'b0, 1'($urandom), d);
            else             bus_wr(1'b1, d);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule